// File: doc/BRIEF.md
# DRAM Bank Command Sequencer

This block drives one DRAM bank. It accepts read and write requests over a valid/ready handshake. Each request carries a row, a starting column, a write flag and a burst length. The block turns each request into the commands the bank needs: row activation, column reads or writes, and precharge.

The block remembers whether the bank is precharged or has a row open, and which row that is. It picks the shortest legal command sequence for the next request:
- a row hit needs the column commands only;
- a precharged bank needs an activation first;
- a row conflict needs a precharge, then an activation.

Four spacing rules are each held by their own down-counter, so a command leaves only once every gap that applies to it has run out.

A policy input selects when rows are closed. Under the open-row policy a row stays open after an access. Under the closed-row policy the bank is precharged after each access, unless the request already waiting at the port targets the same row. A cache-block request is expanded into a run of sequential column commands, one per cycle. A done pulse marks the last column command of the request.

Top module: `dram_bank_seq`

## Requirements
- R1: After reset, req_ready is 1, no command is issued and the bank counts as precharged, so the first request starts with an activation.
- R2: A request to a precharged bank issues an activation (cmd_op 2'b01) of its row, then its column commands. No column command issues earlier than T_RCD cycles after the activation.
- R3: With the open-row policy (closed_pol=0) the row stays open after an access. A later request to that row issues only column commands, with no activation and no precharge.
- R4: A request to a row other than the open one issues a precharge (cmd_op 2'b00) carrying the open row, then an activation, then its columns. The activation comes at least T_RP cycles after the precharge.
- R5: With closed_pol=1 a precharge of the accessed row issues in the cycle after the last column command, unless the R6 case applies.
- R6: With closed_pol=1, if a request is already waiting on the port with the same row when the last column command issues, no precharge is issued, and that waiting request is served as a row hit.
- R7: Two activations are always at least T_RC cycles apart.
- R8: A read (cmd_op 2'b10) never issues earlier than T_WTR cycles after a write (cmd_op 2'b11).
- R9: A request with req_len = n issues n+1 column commands of the same kind and row. The columns start at req_col and step by one, wrapping modulo 2^COL_W. Consecutive commands of a burst leave in consecutive cycles.
- R10: done is 1 exactly in the cycle of a request's last column command. req_ready is 1 only while no request is being served, and no command issues in that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| closed_pol | input | 1 | 1 selects the closed-row policy, 0 the open-row policy |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_row | input | ROW_W | Row of the request |
| req_col | input | COL_W | First column of the request |
| req_wr | input | 1 | 1 for write, 0 for read |
| req_len | input | LEN_W | Number of column accesses minus one |
| cmd_valid | output | 1 | A command issues this cycle |
| cmd_op | output | 2 | 00 precharge, 01 activate, 10 read, 11 write |
| cmd_row | output | ROW_W | Row of the command |
| cmd_col | output | COL_W | Column of a read or write command |
| done | output | 1 | Last column command of the request |

## Verification
The last column command of one request and the closing decision for the next request fall in the same cycle. The precharge choice depends on whether a waiting request hits the same row at that very edge.

The bench provokes this by presenting the next request right after the previous one is accepted, once with the same row and once with a different row. The scoreboard then expects either a plain row hit or a precharge followed by a fresh activation.

A second overlap comes from a read that directly follows a write burst. The write-to-read gap and the row-hit path act in the same cycles, and the bench judges it from the cycle stamps of the commands it sees.

// File: rtl/dram_bank_pkg.sv
package dram_bank_pkg;

    typedef enum logic [1:0] {
        OP_PRE = 2'b00,
        OP_ACT = 2'b01,
        OP_RD  = 2'b10,
        OP_WR  = 2'b11
    } bank_op_e;

    typedef enum logic [1:0] {
        RK_EMPTY,
        RK_HIT,
        RK_CONFLICT
    } row_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WORK,
        ST_CLOSE
    } seq_state_e;

    // Index of each spacing counter
    localparam int GAP_RC  = 0;
    localparam int GAP_RCD = 1;
    localparam int GAP_RP  = 2;
    localparam int GAP_WTR = 3;
    localparam int GAP_N   = 4;

endpackage

// File: rtl/bank_gap_timer.sv
module bank_gap_timer #(
    parameter int unsigned GAP   = 4,
    parameter int unsigned CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic zero_o
);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(GAP - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = RELOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/bank_row_match.sv
module bank_row_match
    import dram_bank_pkg::*;
#(
    parameter int unsigned ROW_W = 14
) (
    input  logic             open_i,
    input  logic [ROW_W-1:0] open_row_i,
    input  logic [ROW_W-1:0] row_i,
    output row_kind_e        kind_o
);
    always_comb begin
        if (!open_i) begin
            kind_o = RK_EMPTY;
        end else if (open_row_i == row_i) begin
            kind_o = RK_HIT;
        end else begin
            kind_o = RK_CONFLICT;
        end
    end
endmodule

// File: rtl/dram_bank_seq.sv
module dram_bank_seq
    import dram_bank_pkg::*;
#(
    parameter int unsigned ROW_W = 14,
    parameter int unsigned COL_W = 11,
    parameter int unsigned LEN_W = 3,
    parameter int unsigned T_RC  = 8,
    parameter int unsigned T_RCD = 3,
    parameter int unsigned T_RP  = 3,
    parameter int unsigned T_WTR = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             closed_pol,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    input  logic             req_wr,
    input  logic [LEN_W-1:0] req_len,
    output logic             cmd_valid,
    output logic [1:0]       cmd_op,
    output logic [ROW_W-1:0] cmd_row,
    output logic [COL_W-1:0] cmd_col,
    output logic             done
);
    localparam int unsigned MAX_A = (T_RC > T_RCD) ? T_RC : T_RCD;
    localparam int unsigned MAX_B = (T_RP > T_WTR) ? T_RP : T_WTR;
    localparam int unsigned MAX_G = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned CNT_W = $clog2(MAX_G + 1);
    localparam int unsigned GAPS [GAP_N] = '{T_RC, T_RCD, T_RP, T_WTR};

    typedef struct packed {
        seq_state_e       state;
        logic             open;
        logic [ROW_W-1:0] open_row;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic             wr;
        logic [LEN_W-1:0] left;
    } seq_regs_t;

    seq_regs_t  r_d, r_q;
    row_kind_e  kind;
    logic [GAP_N-1:0] gap_load;
    logic [GAP_N-1:0] gap_zero;
    bank_op_e   op;

    for (genvar g = 0; g < GAP_N; g++) begin : g_gap
        bank_gap_timer #(
            .GAP   (GAPS[g]),
            .CNT_W (CNT_W)
        ) u_timer (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (gap_load[g]),
            .zero_o (gap_zero[g])
        );
    end

    bank_row_match #(.ROW_W(ROW_W)) u_match (
        .open_i     (r_q.open),
        .open_row_i (r_q.open_row),
        .row_i      (r_q.row),
        .kind_o     (kind)
    );

    always_comb begin
        r_d       = r_q;
        req_ready = 1'b0;
        cmd_valid = 1'b0;
        op        = OP_PRE;
        cmd_row   = r_q.row;
        cmd_col   = r_q.col;
        done      = 1'b0;
        gap_load  = '0;
        unique case (r_q.state)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    r_d.row   = req_row;
                    r_d.col   = req_col;
                    r_d.wr    = req_wr;
                    r_d.left  = req_len;
                    r_d.state = ST_WORK;
                end
            end
            ST_WORK: begin
                unique case (kind)
                    RK_CONFLICT: begin
                        cmd_valid        = 1'b1;
                        op               = OP_PRE;
                        cmd_row          = r_q.open_row;
                        r_d.open         = 1'b0;
                        gap_load[GAP_RP] = 1'b1;
                    end
                    RK_EMPTY: begin
                        if (gap_zero[GAP_RC] && gap_zero[GAP_RP]) begin
                            cmd_valid         = 1'b1;
                            op                = OP_ACT;
                            r_d.open          = 1'b1;
                            r_d.open_row      = r_q.row;
                            gap_load[GAP_RC]  = 1'b1;
                            gap_load[GAP_RCD] = 1'b1;
                        end
                    end
                    default: begin
                        if (gap_zero[GAP_RCD] && (r_q.wr || gap_zero[GAP_WTR])) begin
                            cmd_valid         = 1'b1;
                            op                = r_q.wr ? OP_WR : OP_RD;
                            gap_load[GAP_WTR] = r_q.wr;
                            r_d.col           = r_q.col + 1'b1;
                            r_d.left          = r_q.left - 1'b1;
                            if (r_q.left == '0) begin
                                done = 1'b1;
                                if (closed_pol && !(req_valid && req_row == r_q.row)) begin
                                    r_d.state = ST_CLOSE;
                                end else begin
                                    r_d.state = ST_IDLE;
                                end
                            end
                        end
                    end
                endcase
            end
            default: begin
                cmd_valid        = 1'b1;
                op               = OP_PRE;
                cmd_row          = r_q.open_row;
                r_d.open         = 1'b0;
                gap_load[GAP_RP] = 1'b1;
                r_d.state        = ST_IDLE;
            end
        endcase
        cmd_op = op;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, open: 1'b0, open_row: '0, row: '0,
                     col: '0, wr: 1'b0, left: '0};
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/bank_seq_checker.sv
module bank_seq_checker #(
    parameter int unsigned ROW_W = 14,
    parameter int unsigned COL_W = 11,
    parameter int unsigned T_RC  = 8,
    parameter int unsigned T_RCD = 3,
    parameter int unsigned T_RP  = 3,
    parameter int unsigned T_WTR = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             cmd_valid,
    input logic [1:0]       cmd_op,
    input logic [ROW_W-1:0] cmd_row,
    input logic [COL_W-1:0] cmd_col,
    input logic             done
);
    localparam logic [15:0] SAT = 16'hFFFF;

    logic [15:0] since_act, since_pre, since_wr;
    logic is_act, is_pre, is_wr, is_rd, is_col;

    assign is_act = cmd_valid && cmd_op == 2'b01;
    assign is_pre = cmd_valid && cmd_op == 2'b00;
    assign is_wr  = cmd_valid && cmd_op == 2'b11;
    assign is_rd  = cmd_valid && cmd_op == 2'b10;
    assign is_col = is_wr || is_rd;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_act <= SAT;
            since_pre <= SAT;
            since_wr  <= SAT;
        end else begin
            since_act <= is_act ? 16'd1 : (since_act == SAT ? SAT : since_act + 16'd1);
            since_pre <= is_pre ? 16'd1 : (since_pre == SAT ? SAT : since_pre + 16'd1);
            since_wr  <= is_wr  ? 16'd1 : (since_wr  == SAT ? SAT : since_wr  + 16'd1);
        end
    end

    assert_act_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        is_act |-> since_act >= 16'(T_RC));

    assert_rd_after_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd |-> since_wr >= 16'(T_WTR));

    assert_act_to_col_R2: assert property (@(posedge clk) disable iff (!rst_n)
        is_col |-> since_act >= 16'(T_RCD));

    assert_pre_to_act_R4: assert property (@(posedge clk) disable iff (!rst_n)
        is_act |-> since_pre >= 16'(T_RP));

    assert_done_on_col_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> is_col);

    assert_ready_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !cmd_valid);

    assert_burst_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_col && $past(is_col) && !$past(done)) |->
            (cmd_col == COL_W'($past(cmd_col) + 1'b1) && cmd_row == $past(cmd_row)
             && cmd_op == $past(cmd_op)));
endmodule

bind dram_bank_seq bank_seq_checker #(
    .ROW_W (ROW_W),
    .COL_W (COL_W),
    .T_RC  (T_RC),
    .T_RCD (T_RCD),
    .T_RP  (T_RP),
    .T_WTR (T_WTR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_row   (cmd_row),
    .cmd_col   (cmd_col),
    .done      (done)
);

// File: tb/dram_bank_seq_bench.sv
module dram_bank_seq_bench;
    localparam int ROW_W = 14;
    localparam int COL_W = 11;
    localparam int LEN_W = 3;
    localparam int T_RC  = 8;
    localparam int T_RCD = 3;
    localparam int T_RP  = 3;
    localparam int T_WTR = 4;
    localparam int WATCHDOG = 20000;

    typedef struct {
        logic [1:0] op;
        int         row;
        int         col;
        bit         last;
        string      tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             closed_pol = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic             req_wr = 1'b0;
    logic [LEN_W-1:0] req_len = '0;
    logic             cmd_valid;
    logic [1:0]       cmd_op;
    logic [ROW_W-1:0] cmd_row;
    logic [COL_W-1:0] cmd_col;
    logic             done;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails = 0;
    int   cyc = 0;
    int   last_act = -1000;
    int   last_pre = -1000;
    int   last_wr = -1000;
    bit   m_open = 0;
    int   m_row = 0;
    bit   finished = 0;

    always #10 clk = ~clk;

    dram_bank_seq #(
        .ROW_W(ROW_W), .COL_W(COL_W), .LEN_W(LEN_W),
        .T_RC(T_RC), .T_RCD(T_RCD), .T_RP(T_RP), .T_WTR(T_WTR)
    ) u_dram_bank_seq (
        .clk(clk), .rst_n(rst_n), .closed_pol(closed_pol),
        .req_valid(req_valid), .req_ready(req_ready), .req_row(req_row),
        .req_col(req_col), .req_wr(req_wr), .req_len(req_len),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_row(cmd_row),
        .cmd_col(cmd_col), .done(done)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    task automatic push(input logic [1:0] op, input int row, input int col,
                        input bit last, input string tag);
        exp_t e;
        e.op = op; e.row = row; e.col = col; e.last = last; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Expectations follow from R2..R6 and R9.
    task automatic send(input int row, input int col, input bit wr, input int len,
                        input bit next_same);
        string ctag;
        ctag = (m_open && m_row == row) ? (closed_pol ? "R6" : "R3") : "R9";
        if (m_open && m_row != row) begin
            push(2'b00, m_row, 0, 0, "R4");
            m_open = 0;
        end
        if (!m_open) begin
            push(2'b01, row, 0, 0, "R2");
            m_open = 1;
            m_row = row;
        end
        for (int b = 0; b <= len; b++) begin
            push(wr ? 2'b11 : 2'b10, row, (col + b) % (1 << COL_W), b == len, ctag);
        end
        if (closed_pol && !next_same) begin
            push(2'b00, row, 0, 0, "R5");
            m_open = 0;
        end
        @(negedge clk);
        req_valid = 1'b1;
        req_row = ROW_W'(row);
        req_col = COL_W'(col);
        req_wr = wr;
        req_len = LEN_W'(len);
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (exp_q.size() != 0 || !req_ready);
        repeat (3) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WATCHDOG && !finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog R10 actual=%0d expected=%0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Monitor: compares each issued command with the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (cmd_valid) begin
                if (exp_q.size() == 0) begin
                    check(0, "R10", "unexpected command op", int'(cmd_op), -1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(cmd_op == e.op, e.tag, "op", int'(cmd_op), int'(e.op));
                    check(int'(cmd_row) == e.row, e.tag, "row", int'(cmd_row), e.row);
                    if (e.op[1]) begin
                        check(int'(cmd_col) == e.col, e.tag, "col", int'(cmd_col), e.col);
                    end
                    check(done == e.last, "R10", "done", int'(done), int'(e.last));
                end
                if (cmd_op == 2'b01) begin
                    check(cyc - last_act >= T_RC, "R7", "act spacing", cyc - last_act, T_RC);
                    check(cyc - last_pre >= T_RP, "R4", "pre to act", cyc - last_pre, T_RP);
                    last_act = cyc;
                end
                if (cmd_op == 2'b00) last_pre = cyc;
                if (cmd_op[1]) begin
                    check(cyc - last_act >= T_RCD, "R2", "act to col", cyc - last_act, T_RCD);
                end
                if (cmd_op == 2'b10) begin
                    check(cyc - last_wr >= T_WTR, "R8", "write to read", cyc - last_wr, T_WTR);
                end
                if (cmd_op == 2'b11) last_wr = cyc;
            end else begin
                check(done == 1'b0, "R10", "done without command", int'(done), 0);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
        check(cmd_valid == 1'b0, "R1", "no command after reset", int'(cmd_valid), 0);

        // Open-row policy
        closed_pol = 1'b0;
        send(5, 0, 0, 7, 0);     // R1/R2: precharged bank, 8-beat block
        send(5, 8, 0, 1, 0);     // R3: hit
        send(9, 3, 1, 0, 0);     // R4/R7: conflict
        send(9, 4, 0, 0, 0);     // R8: read after write on a hit
        wait_idle();

        // Closed-row policy
        closed_pol = 1'b1;
        send(2, 10, 0, 3, 1);    // R6: next waiting request hits row 2
        send(2, 0, 1, 0, 0);     // R5: next request differs, so precharge
        send(7, 2047, 0, 1, 0);  // R9: column wrap, then R5 precharge
        wait_idle();

        // Back to open-row policy
        closed_pol = 1'b0;
        send(1, 0, 1, 2, 0);
        send(1, 5, 0, 0, 0);     // R8 and R3
        wait_idle();

        check(exp_q.size() == 0, "R10", "scoreboard drained", exp_q.size(), 0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule